// File: doc/BRIEF.md
# OTG Session Request Pulse Sequencer

This block drives the signalling with which a B-device asks a dormant bus to begin a session. One start strobe launches a fixed, ordered sequence. First the block enables a VBus discharge path and holds it until the synchronized VBus level code reports the bus below the session-end threshold. It then waits for the bus line state to stay at single-ended zero for longer than a qualification time. After that it pulses the data line and then, with no gap and no overlap, pulses VBus. Each duration is a cycle count that is derived from the clock rate in kHz and a time in microseconds, both of which are parameters.

The caller sees `busy` for the whole sequence and a single-cycle `done` when it completes. An abort, or a second start while the block is busy, sends the block straight back to idle with every enable low. Role detection, host operation and the analog drivers that these enables control sit outside this block.

Top module: `srp_seq`

## Requirements
- R1: A start in idle (without abort) raises the discharge enable and busy in the next cycle.
- R2: The discharge enable stays high while the VBus level code is not 2'b00. The first sample of 2'b00 drops the discharge enable in the next cycle, and the block then enters the SE0 wait with every enable low.
- R3: In the SE0 wait, the data-line pulse enable rises in the cycle after the line state (2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = treated as non-SE0) has been sampled as SE0 on SE0_CYC+1 consecutive cycles. SE0_CYC = CLK_KHZ*SE0_US/1000. A run of only SE0_CYC samples does not start the pulse.
- R4: Any non-SE0 sample during the SE0 wait restarts the consecutive count from zero.
- R5: The data-line pulse enable stays high for exactly CLK_KHZ*DPULSE_US/1000 cycles. The VBus pulse enable rises in the next cycle and stays high for exactly CLK_KHZ*VPULSE_US/1000 cycles. The two enables are never high together.
- R6: Done is high for exactly one cycle, in the cycle right after the VBus pulse ends, and busy is low in that cycle.
- R7: An abort while busy sets every enable and busy low in the next cycle and produces no done.
- R8: A start while busy acts like an abort: the block returns to idle, not to the start of the sequence.
- R9: Under reset every output is low.
- R10: In idle, an abort has no effect, and an abort together with a start keeps the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe |
| abort_i | input | 1 | Cancel strobe |
| vbus_lvl_i | input | 2 | Synchronized VBus level code, 2'b00 = below session end |
| line_st_i | input | 2 | Bus line state, 2'b00 = SE0 |
| vbus_dis_o | output | 1 | VBus discharge enable |
| dline_pulse_o | output | 1 | Data-line pulse enable |
| vbus_pulse_o | output | 1 | VBus pulse enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_KHZ = 100 and leaves the microsecond parameters at their defaults. That gives a qualification of 200 cycles, a data-line pulse of 700 cycles and a VBus pulse of 1000 cycles, so whole sequences fit many times into one run. The SE0 run that falls exactly one sample short of qualifying can be driven directly, as can restarts of the count partway through and aborts inside each phase. Long random stretches of line state and VBus level then run against a cycle model of the bench's own.

// File: rtl/srp_pkg.sv
package srp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_SE0,
    ST_DPUL,
    ST_VPUL
  } srp_state_e;

  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] VBUS_LOW = 2'b00;

  function automatic int unsigned us_to_cycles(int unsigned khz, int unsigned us);
    return (khz * us) / 1000;
  endfunction

  function automatic int unsigned cnt_bits(int unsigned max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/srp_se0_qual.sv
module srp_se0_qual #(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic se0_i,
  output logic qual_o
);
  localparam int unsigned W = srp_pkg::cnt_bits(LIMIT);

  logic [W-1:0] cnt_q;
  logic         at_limit;

  assign at_limit = (cnt_q == W'(LIMIT));
  assign qual_o   = arm_i && se0_i && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!arm_i || !se0_i)  cnt_q <= '0;
    else if (!at_limit)         cnt_q <= cnt_q + W'(1);
  end

  // R4: a non-SE0 sample while armed clears the run
  p_cnt_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && !se0_i) |=> (cnt_q == '0));

  // R3: the count grows by one per consecutive SE0 sample
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && se0_i && !at_limit) |=> (cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/srp_pulse_timer.sv
module srp_pulse_timer #(
  parameter int unsigned LEN = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int unsigned W = srp_pkg::cnt_bits(LEN);

  logic [W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  // R5: the count never passes the pulse length while running
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q < W'(LEN)));

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic vbus_low_i,
  input  logic se0_qual_i,
  input  logic dp_last_i,
  input  logic vb_last_i,
  output logic se0_arm_o,
  output logic dis_o,
  output logic dp_o,
  output logic vb_o,
  output logic busy_o,
  output logic done_o
);
  srp_state_e state_q, state_d;
  logic       finish;
  logic       cancel;
  logic       done_q;

  assign cancel = (state_q != ST_IDLE) && (start_i || abort_i);

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    if (cancel) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (start_i && !abort_i) state_d = ST_DRAIN;
        ST_DRAIN: if (vbus_low_i)          state_d = ST_SE0;
        ST_SE0:   if (se0_qual_i)          state_d = ST_DPUL;
        ST_DPUL:  if (dp_last_i)           state_d = ST_VPUL;
        ST_VPUL:  if (vb_last_i) begin
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                  end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  assign se0_arm_o = (state_q == ST_SE0);
  assign dis_o     = (state_q == ST_DRAIN);
  assign dp_o      = (state_q == ST_DPUL);
  assign vb_o      = (state_q == ST_VPUL);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !abort_i) |=> (dis_o && busy_o));

  p_drain_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_o && !vbus_low_i && !start_i && !abort_i) |=> dis_o);

  p_drain_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_o && vbus_low_i && !start_i && !abort_i) |=> (se0_arm_o && !dis_o && !dp_o && !vb_o));

  p_dp_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_o) |-> $past(se0_qual_i));

  p_vb_after_dp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vb_o) |-> $past(dp_o && dp_last_i));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(vb_o)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i) |=> (!busy_o && !done_o && !dis_o && !dp_o && !vb_o));

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (!busy_o && !done_o));

  p_idle_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && abort_i) |=> !busy_o);

endmodule

// File: rtl/srp_seq.sv
module srp_seq
  import srp_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 50000,
  parameter int unsigned SE0_US     = 2000,
  parameter int unsigned DPULSE_US  = 7000,
  parameter int unsigned VPULSE_US  = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic [1:0] vbus_lvl_i,
  input  logic [1:0] line_st_i,
  output logic       vbus_dis_o,
  output logic       dline_pulse_o,
  output logic       vbus_pulse_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int unsigned SE0_CYC = us_to_cycles(CLK_KHZ, SE0_US);
  localparam int unsigned DP_CYC  = us_to_cycles(CLK_KHZ, DPULSE_US);
  localparam int unsigned VB_CYC  = us_to_cycles(CLK_KHZ, VPULSE_US);

  logic       vbus_low;
  logic       line_se0;
  logic       se0_arm;
  logic       se0_qual;
  logic [1:0] pul_run;
  logic [1:0] pul_last;

  assign vbus_low = (vbus_lvl_i == VBUS_LOW);
  assign line_se0 = (line_st_i == LINE_SE0);

  srp_se0_qual #(.LIMIT(SE0_CYC)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_i  (se0_arm),
    .se0_i  (line_se0),
    .qual_o (se0_qual)
  );

  assign pul_run = {vbus_pulse_o, dline_pulse_o};

  for (genvar g = 0; g < 2; g++) begin : g_pulse
    localparam int unsigned LEN_G = (g == 0) ? DP_CYC : VB_CYC;
    srp_pulse_timer #(.LEN(LEN_G)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (pul_run[g]),
      .last_o (pul_last[g])
    );
  end

  srp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .vbus_low_i (vbus_low),
    .se0_qual_i (se0_qual),
    .dp_last_i  (pul_last[0]),
    .vb_last_i  (pul_last[1]),
    .se0_arm_o  (se0_arm),
    .dis_o      (vbus_dis_o),
    .dp_o       (dline_pulse_o),
    .vb_o       (vbus_pulse_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  // R5: data-line and VBus pulses never coincide at the ports
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({vbus_dis_o, dline_pulse_o, vbus_pulse_o}) <= 1);

endmodule

// File: tb/srp_seq_tb.sv
module srp_seq_tb;
  localparam int unsigned KHZ = 100;

  function automatic int cyc_of(int unsigned us);
    int r;
    r = int'(KHZ) * int'(us);
    return r / 1000;
  endfunction

  localparam int SE0_N = 200;
  localparam int DP_N  = 700;
  localparam int VB_N  = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       abort_i = 1'b0;
  logic [1:0] vbus_lvl_i = 2'b11;
  logic [1:0] line_st_i = 2'b01;
  logic       vbus_dis_o, dline_pulse_o, vbus_pulse_o, busy_o, done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  srp_seq #(.CLK_KHZ(KHZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .vbus_lvl_i(vbus_lvl_i), .line_st_i(line_st_i),
    .vbus_dis_o(vbus_dis_o), .dline_pulse_o(dline_pulse_o),
    .vbus_pulse_o(vbus_pulse_o), .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk = ~clk;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Reference model: phase 0 idle, 1 drain, 2 SE0 wait, 3 line pulse, 4 VBus pulse
  int m_ph = 0;
  int m_run = 0;
  bit m_done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_run = 0; m_done = 1'b0;
    end else begin
      m_done = 1'b0;
      if (m_ph != 0 && (start_i || abort_i)) begin
        m_ph = 0; m_run = 0;
      end else begin
        case (m_ph)
          0: if (start_i && !abort_i) begin m_ph = 1; m_run = 0; end
          1: if (vbus_lvl_i == 2'b00) begin m_ph = 2; m_run = 0; end
          2: begin
               if (line_st_i != 2'b00) m_run = 0;
               else begin
                 m_run++;
                 if (m_run > SE0_N) begin m_ph = 3; m_run = 0; end
               end
             end
          3: begin
               m_run++;
               if (m_run == DP_N) begin m_ph = 4; m_run = 0; end
             end
          default: begin
               m_run++;
               if (m_run == VB_N) begin m_ph = 0; m_run = 0; m_done = 1'b1; end
             end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (vbus_dis_o != (m_ph == 1))
        check(0, "R2 model discharge", vbus_dis_o, m_ph == 1);
      else if (dline_pulse_o != (m_ph == 3))
        check(0, "R3 model line pulse", dline_pulse_o, m_ph == 3);
      else if (vbus_pulse_o != (m_ph == 4))
        check(0, "R5 model vbus pulse", vbus_pulse_o, m_ph == 4);
      else if (busy_o != (m_ph != 0))
        check(0, "R7 model busy", busy_o, m_ph != 0);
      else if (done_o != m_done)
        check(0, "R6 model done", done_o, m_done);
      else
        check(1, "model", 0, 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(0, "watchdog", 0, 1);
      summary();
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic to_wait();
    line_st_i = 2'b01; vbus_lvl_i = 2'b10;
    pulse_start();
    tick(5);
    vbus_lvl_i = 2'b00; tick();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy_o; i++) tick();
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    if (cyc_of(2000) != SE0_N || cyc_of(7000) != DP_N || cyc_of(10000) != VB_N)
      $display("cycle constants differ from parameter arithmetic");
    tick(3);
    check(!vbus_dis_o && !dline_pulse_o && !vbus_pulse_o && !busy_o && !done_o,
          "R9 reset outputs", {vbus_dis_o, dline_pulse_o, vbus_pulse_o, busy_o, done_o}, 0);
    rst_n = 1'b1; tick(2);

    // R10: abort alone, and abort with start, in idle
    abort_i = 1'b1; tick(); abort_i = 1'b0;
    check(!busy_o, "R10 idle abort", busy_o, 0);
    abort_i = 1'b1; start_i = 1'b1; tick(); abort_i = 1'b0; start_i = 1'b0;
    check(!busy_o && !vbus_dis_o, "R10 abort with start", busy_o, 0);

    // R1 and R2
    vbus_lvl_i = 2'b11; line_st_i = 2'b00;
    pulse_start();
    check(vbus_dis_o && busy_o, "R1 start raises discharge", vbus_dis_o, 1);
    tick(40);
    check(vbus_dis_o, "R2 discharge held", vbus_dis_o, 1);
    vbus_lvl_i = 2'b00; line_st_i = 2'b01; tick();
    check(!vbus_dis_o && busy_o && !dline_pulse_o, "R2 discharge drops", vbus_dis_o, 0);

    // R3 boundary: SE0_N samples only
    line_st_i = 2'b00; tick(SE0_N);
    line_st_i = 2'b10; tick(3);
    check(!dline_pulse_o, "R3 short run no pulse", dline_pulse_o, 0);

    // R4: interrupted run, then full run measured
    line_st_i = 2'b00; tick(150);
    line_st_i = 2'b11; tick();
    line_st_i = 2'b00;
    n = 0;
    for (int i = 0; i < 1000 && !dline_pulse_o; i++) begin tick(); n++; end
    check(n == SE0_N + 1, "R4 count restarted", n, SE0_N + 1);

    // R5, R6
    n = 0;
    for (int i = 0; i < 2000 && dline_pulse_o; i++) begin n++; tick(); end
    check(n == DP_N, "R5 line pulse width", n, DP_N);
    check(vbus_pulse_o, "R5 vbus follows at once", vbus_pulse_o, 1);
    n = 0;
    for (int i = 0; i < 2000 && vbus_pulse_o; i++) begin n++; tick(); end
    check(n == VB_N, "R5 vbus pulse width", n, VB_N);
    check(done_o && !busy_o, "R6 done with busy low", done_o, 1);
    tick();
    check(!done_o, "R6 done one cycle", done_o, 0);

    // R7: abort in each phase
    for (int ph = 0; ph < 4; ph++) begin
      line_st_i = 2'b01; vbus_lvl_i = 2'b01;
      pulse_start();
      if (ph > 0) begin vbus_lvl_i = 2'b00; tick(); end
      if (ph > 1) begin line_st_i = 2'b00; tick(SE0_N + 1 + 10); end
      if (ph > 2) tick(DP_N);
      abort_i = 1'b1; tick(); abort_i = 1'b0;
      check(!busy_o && !vbus_dis_o && !dline_pulse_o && !vbus_pulse_o && !done_o,
            "R7 abort to idle", busy_o, 0);
      tick(2);
    end

    // R8: start while busy in the line pulse
    to_wait();
    line_st_i = 2'b00; tick(SE0_N + 1 + 20);
    pulse_start();
    check(!busy_o && !dline_pulse_o, "R8 start while busy", busy_o, 0);
    tick(5);
    check(!busy_o && !vbus_dis_o, "R8 stays idle", vbus_dis_o, 0);

    // random stretches checked against the model
    for (int r = 0; r < 14; r++) begin
      pulse_start();
      for (int c = 0; c < 2500; c++) begin
        vbus_lvl_i = ($urandom % 5 == 0) ? 2'b00 : 2'(1 + $urandom % 3);
        line_st_i  = ($urandom % 100 < 97) ? 2'b00 : 2'($urandom % 4);
        abort_i    = ($urandom % 4000 == 0);
        start_i    = ($urandom % 5000 == 0);
        tick();
      end
      abort_i = 1'b0; start_i = 1'b0;
      wait_idle();
      tick(2);
    end

    finished = 1'b1;
    summary();
  end
endmodule